// File: doc/BRIEF.md
# Paged Address Translation and Protection Unit

This unit turns a 17-bit word address issued by a processor into a 22-bit real word address and decides whether the access may proceed. When translation is switched on, the upper eight address bits pick one of 256 page-frame entries. Each entry is 13 bits wide and replaces those bits, while the 9-bit offset inside a 512-word page passes through unchanged. The same eight bits also pick a 2-bit permission code that limits the access to some mix of read, write and instruction fetch, or forbids it.

A second check works on the real side and does not depend on the first. Each 512-word real page in the lowest 128K words carries a 2-bit lock, and every request carries a 2-bit key taken from the program status. An open page or the master key always passes. In every other case the key must equal the lock. Word addresses 0 to 15 name general registers. They skip both translation and both checks, and come back flagged as register references.

The three tables are written one entry per clock through a load port. A request is taken in one cycle and its answer is registered. The response logic is a two-state machine. It sits in RSP_IDLE and takes the transition ACCEPT to RSP_HOLD on a valid request. While more requests arrive it stays in RSP_HOLD through the transition STREAM. It takes the transition DRAIN back to RSP_IDLE in a cycle with no request. The response is valid only in RSP_HOLD.

Top module: `pgx_xlate`

## Requirements
- R1: A request whose virtual address is below 16 returns rsp_is_reg=1 and rsp_raddr equal to the zero-extended virtual address, whether mapping is on or off.
- R2: With req_map_en=1 and a virtual address of 16 or more, rsp_raddr is {page-frame entry[vaddr[16:9]], vaddr[8:0]}.
- R3: With req_map_en=0 and a virtual address of 16 or more, rsp_raddr is the zero-extended virtual address and rsp_acc_fault is 0 whatever the permission code.
- R4: req_kind encodes 00 read, 01 write, 10 fetch, 11 handled as read. Permission code 00 allows all kinds, 01 forbids write, 10 allows read only, and 11 forbids all kinds. A forbidden kind on a mapped request sets rsp_acc_fault.
- R5: rsp_lock_fault is 1 only when the lock of the real page is not 00, the key is not 00, and the key differs from the lock.
- R6: The lock check uses lock entry rsp_raddr[16:8+1] and applies only when rsp_raddr[21:17] is zero. Real addresses of 128K words and above never set rsp_lock_fault.
- R7: rsp_valid is 1 in exactly the cycle after each cycle with req_valid=1, including back-to-back requests, and 0 otherwise.
- R8: Reset clears every page-frame entry, permission code and lock to zero.
- R9: ld_sel selects the table written when ld_en=1: 00 page frames (ld_data[12:0]), 01 permission codes (ld_data[1:0]), 10 locks (ld_data[1:0]), 11 writes nothing. A request in the same cycle as a load sees the old entry, and the next request sees the new one.
- R10: A register reference always returns rsp_acc_fault=0 and rsp_lock_fault=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Table write strobe |
| ld_sel | input | 2 | Table select for the write |
| ld_idx | input | 8 | Entry index for the write |
| ld_data | input | 13 | Write data |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 17 | Virtual word address |
| req_kind | input | 2 | Access kind |
| req_map_en | input | 1 | Translation enable |
| req_key | input | 2 | Key from program status |
| rsp_valid | output | 1 | Response valid |
| rsp_raddr | output | 22 | Real word address or register number |
| rsp_is_reg | output | 1 | Register reference |
| rsp_acc_fault | output | 1 | Permission violation |
| rsp_lock_fault | output | 1 | Lock violation |

## Verification
A corrupted page-frame, permission or lock entry is invisible until a request reaches that page. It then shows up in the very next response as a wrong upper address field or a wrong fault flag. The bench therefore loads entries that differ from the reset value, requests each page right away, and requests the same page in the cycle of a load. This exposes both a lost write and one that lands too early. A wrong state in the response machine shows up within one cycle as a missing, doubled or unrequested rsp_valid. The bench checks rsp_valid on every cycle.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        TGT_FRAME = 2'b00,
        TGT_PERM  = 2'b01,
        TGT_LOCK  = 2'b10,
        TGT_NONE  = 2'b11
    } ld_tgt_e;

    typedef enum logic [1:0] {
        PERM_ALL  = 2'b00,
        PERM_RX   = 2'b01,
        PERM_RO   = 2'b10,
        PERM_NONE = 2'b11
    } perm_code_e;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_HOLD = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/pgx_entry_table.sv
module pgx_entry_table #(
    parameter int ENT_W = 13,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] ent_q [DEPTH];

    // R8: every entry clears on reset; R9: one write per clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/pgx_perm_check.sv
module pgx_perm_check
    import pgx_pkg::*;
(
    input  logic       chk_en,
    input  logic [1:0] code,
    input  logic [1:0] kind,
    output logic       fault
);
    logic is_write;
    logic is_fetch;
    logic deny;

    assign is_write = (acc_kind_e'(kind) == ACC_WRITE);
    assign is_fetch = (acc_kind_e'(kind) == ACC_FETCH);

    // R4: permission decode; reserved kind behaves as read
    always_comb begin
        unique case (perm_code_e'(code))
            PERM_ALL:  deny = 1'b0;
            PERM_RX:   deny = is_write;
            PERM_RO:   deny = is_write | is_fetch;
            PERM_NONE: deny = 1'b1;
            default:   deny = 1'b1;
        endcase
    end

    assign fault = chk_en & deny;

endmodule

// File: rtl/pgx_lock_check.sv
module pgx_lock_check #(
    parameter int RA_W   = 22,
    parameter int OFF_W  = 9,
    parameter int LIDX_W = 8,
    parameter int KEY_W  = 2
) (
    input  logic              chk_en,
    input  logic [RA_W-1:0]   raddr,
    input  logic [KEY_W-1:0]  key,
    input  logic [KEY_W-1:0]  lock_val,
    output logic [LIDX_W-1:0] lock_idx,
    output logic              fault
);
    localparam int TOP_LO = OFF_W + LIDX_W;

    logic in_range;
    logic open_page;
    logic master;

    assign lock_idx  = raddr[TOP_LO-1:OFF_W];
    // R6: only the low real region carries locks
    assign in_range  = (raddr[RA_W-1:TOP_LO] == '0);
    // R5: open page, master key, otherwise key must match
    assign open_page = (lock_val == '0);
    assign master    = (key == '0);
    assign fault     = chk_en & in_range & ~open_page & ~master & (key != lock_val);

endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
    import pgx_pkg::*;
#(
    parameter int VA_W    = 17,
    parameter int OFF_W   = 9,
    parameter int FRAME_W = 13,
    parameter int REG_CNT = 16,
    parameter int LIDX_W  = 8,
    parameter int KEY_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en,
    input  logic [1:0]                    ld_sel,
    input  logic [VA_W-OFF_W-1:0]         ld_idx,
    input  logic [FRAME_W-1:0]            ld_data,
    input  logic                          req_valid,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic [1:0]                    req_kind,
    input  logic                          req_map_en,
    input  logic [KEY_W-1:0]              req_key,
    output logic                          rsp_valid,
    output logic [FRAME_W+OFF_W-1:0]      rsp_raddr,
    output logic                          rsp_is_reg,
    output logic                          rsp_acc_fault,
    output logic                          rsp_lock_fault
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int RA_W  = FRAME_W + OFF_W;

    // load decode (R9)
    logic wr_frame, wr_perm, wr_lock;
    assign wr_frame = ld_en & (ld_tgt_e'(ld_sel) == TGT_FRAME);
    assign wr_perm  = ld_en & (ld_tgt_e'(ld_sel) == TGT_PERM);
    assign wr_lock  = ld_en & (ld_tgt_e'(ld_sel) == TGT_LOCK);

    logic [VPN_W-1:0]   vpn;
    logic [FRAME_W-1:0] frame_rd;
    logic [1:0]         perm_rd;
    logic [KEY_W-1:0]   lock_rd;
    logic [LIDX_W-1:0]  lock_idx;
    logic               is_reg;
    logic [RA_W-1:0]    raddr_c;
    logic               acc_f, lock_f;

    assign vpn    = req_vaddr[VA_W-1:OFF_W];
    assign is_reg = (req_vaddr < VA_W'(REG_CNT));

    pgx_entry_table #(.ENT_W(FRAME_W), .IDX_W(VPN_W)) frame_tbl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_frame), .wr_idx(ld_idx),
        .wr_data(ld_data), .rd_idx(vpn), .rd_data(frame_rd)
    );

    pgx_entry_table #(.ENT_W(2), .IDX_W(VPN_W)) perm_tbl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_perm), .wr_idx(ld_idx),
        .wr_data(ld_data[1:0]), .rd_idx(vpn), .rd_data(perm_rd)
    );

    pgx_entry_table #(.ENT_W(KEY_W), .IDX_W(LIDX_W)) lock_tbl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_lock), .wr_idx(ld_idx[LIDX_W-1:0]),
        .wr_data(ld_data[KEY_W-1:0]), .rd_idx(lock_idx), .rd_data(lock_rd)
    );

    // R1 R2 R3: real address formation
    always_comb begin
        if (is_reg || !req_map_en) begin
            raddr_c = RA_W'(req_vaddr);
        end else begin
            raddr_c = {frame_rd, req_vaddr[OFF_W-1:0]};
        end
    end

    pgx_perm_check perm_chk_i (
        .chk_en(req_map_en & ~is_reg), .code(perm_rd), .kind(req_kind), .fault(acc_f)
    );

    pgx_lock_check #(.RA_W(RA_W), .OFF_W(OFF_W), .LIDX_W(LIDX_W), .KEY_W(KEY_W)) lock_chk_i (
        .chk_en(~is_reg), .raddr(raddr_c), .key(req_key), .lock_val(lock_rd),
        .lock_idx(lock_idx), .fault(lock_f)
    );

    // R7: response state machine
    rsp_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            RSP_IDLE: state_d = req_valid ? RSP_HOLD : RSP_IDLE;  // ACCEPT
            RSP_HOLD: state_d = req_valid ? RSP_HOLD : RSP_IDLE;  // STREAM / DRAIN
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: rsp_valid = 1'b0;
            RSP_HOLD: rsp_valid = 1'b1;
            default:  rsp_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_raddr      <= '0;
            rsp_is_reg     <= 1'b0;
            rsp_acc_fault  <= 1'b0;
            rsp_lock_fault <= 1'b0;
        end else if (req_valid) begin
            rsp_raddr      <= raddr_c;
            rsp_is_reg     <= is_reg;
            rsp_acc_fault  <= acc_f;
            rsp_lock_fault <= lock_f;
        end
    end

    // assertions
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R7
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);  // R7
    AST_REG_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_is_reg) |-> (!rsp_acc_fault && !rsp_lock_fault));  // R10
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_map_en && req_vaddr >= VA_W'(REG_CNT))
        |=> rsp_raddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));  // R2
    AST_UNMAPPED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_map_en) |=> (!rsp_acc_fault && rsp_raddr[RA_W-1:VA_W] == '0));  // R3
    AST_MASTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_key == '0) |=> !rsp_lock_fault);  // R5
    AST_REG_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr < VA_W'(REG_CNT)) |=> (rsp_is_reg && rsp_raddr == RA_W'($past(req_vaddr))));  // R1

endmodule

// File: tb/pgx_xlate_tb_top.sv
module pgx_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [7:0]  ld_idx = '0;
    logic [12:0] ld_data = '0;
    logic        req_valid = 1'b0;
    logic [16:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_map_en = 1'b0;
    logic [1:0]  req_key = '0;
    logic        rsp_valid;
    logic [21:0] rsp_raddr;
    logic        rsp_is_reg, rsp_acc_fault, rsp_lock_fault;

    always #2 clk = ~clk;  // 250 MHz

    pgx_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
        .ld_data(ld_data), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_map_en(req_map_en), .req_key(req_key),
        .rsp_valid(rsp_valid), .rsp_raddr(rsp_raddr), .rsp_is_reg(rsp_is_reg),
        .rsp_acc_fault(rsp_acc_fault), .rsp_lock_fault(rsp_lock_fault)
    );

    typedef struct {
        int          stamp;
        logic [21:0] ra;
        logic        isr;
        logic        af;
        logic        lf;
        string       tag;
    } item_t;

    item_t q[$];
    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    done = 1'b0;

    logic [12:0] m_frame [256];
    logic [1:0]  m_perm  [256];
    logic [1:0]  m_lock  [256];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    function automatic item_t model(input logic [16:0] va, input logic [1:0] kind,
                                    input logic men, input logic [1:0] key, input string tag);
        item_t it;
        logic [1:0] code, lk;
        it.tag = tag;
        it.stamp = 0;
        if (va < 17'd16) begin
            it.ra = {5'b0, va}; it.isr = 1'b1; it.af = 1'b0; it.lf = 1'b0;
            return it;
        end
        it.isr = 1'b0;
        it.ra = men ? {m_frame[va[16:9]], va[8:0]} : {5'b0, va};
        code = m_perm[va[16:9]];
        case (code)
            2'b00: it.af = 1'b0;
            2'b01: it.af = (kind == 2'b01);
            2'b10: it.af = (kind == 2'b01) || (kind == 2'b10);
            default: it.af = 1'b1;
        endcase
        if (!men) it.af = 1'b0;
        lk = m_lock[it.ra[16:9]];
        it.lf = (it.ra[21:17] == 5'd0) && (lk != 2'd0) && (key != 2'd0) && (key != lk);
        return it;
    endfunction

    task automatic model_load(input logic [1:0] sel, input logic [7:0] idx, input logic [12:0] d);
        case (sel)
            2'b00: m_frame[idx] = d;
            2'b01: m_perm[idx]  = d[1:0];
            2'b10: m_lock[idx]  = d[1:0];
            default: ;
        endcase
    endtask

    task automatic send(input logic [16:0] va, input logic [1:0] kind,
                        input logic men, input logic [1:0] key, input string tag);
        item_t it;
        @(negedge clk);
        ld_en = 1'b0;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_map_en = men; req_key = key;
        it = model(va, kind, men, key, tag);
        it.stamp = cyc;
        q.push_back(it);
    endtask

    task automatic load(input logic [1:0] sel, input logic [7:0] idx, input logic [12:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        ld_en = 1'b1; ld_sel = sel; ld_idx = idx; ld_data = d;
        model_load(sel, idx, d);
    endtask

    // load and request in the same cycle: request must see the old entry (R9)
    task automatic load_and_send(input logic [1:0] sel, input logic [7:0] idx, input logic [12:0] d,
                                 input logic [16:0] va, input logic [1:0] key, input string tag);
        item_t it;
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_idx = idx; ld_data = d;
        req_valid = 1'b1; req_vaddr = va; req_kind = 2'b00; req_map_en = 1'b1; req_key = key;
        it = model(va, 2'b00, 1'b1, key, tag);
        it.stamp = cyc;
        q.push_back(it);
        model_load(sel, idx, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ld_en = 1'b0; req_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].stamp + 1 == cyc) begin
                item_t e;
                e = q.pop_front();
                check(rsp_valid === 1'b1, "R7", $sformatf("%s rsp_valid=%b exp=1", e.tag, rsp_valid));
                check(rsp_raddr === e.ra, e.tag, $sformatf("raddr=%h exp=%h", rsp_raddr, e.ra));
                check(rsp_is_reg === e.isr, e.tag, $sformatf("is_reg=%b exp=%b", rsp_is_reg, e.isr));
                check(rsp_acc_fault === e.af, e.tag, $sformatf("acc_fault=%b exp=%b", rsp_acc_fault, e.af));
                check(rsp_lock_fault === e.lf, e.tag, $sformatf("lock_fault=%b exp=%b", rsp_lock_fault, e.lf));
            end else begin
                check(rsp_valid === 1'b0, "R7", $sformatf("idle rsp_valid=%b exp=0", rsp_valid));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_frame[i] = '0; m_perm[i] = '0; m_lock[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R8", $sformatf("reset rsp_valid=%b exp=0", rsp_valid));
        rst_n = 1'b1;
        idle(2);

        // R8: cleared tables translate to frame 0, no faults
        send(17'h1234, 2'b00, 1'b1, 2'd1, "R8");
        send(17'h1F0AA, 2'b01, 1'b1, 2'd3, "R8");
        idle(1);

        // R1 R10: register references ignore mapping and both checks
        load(2'b01, 8'h00, 13'd3);
        load(2'b10, 8'h00, 13'd2);
        send(17'd5, 2'b01, 1'b1, 2'd1, "R1_R10");
        send(17'd15, 2'b10, 1'b0, 2'd3, "R1_R10");
        send(17'd0, 2'b00, 1'b1, 2'd1, "R1_R10");
        send(17'd16, 2'b00, 1'b1, 2'd1, "R4_R5");   // first non-register word
        idle(1);

        // R2: translation
        load(2'b00, 8'h12, 13'h0AB);
        load(2'b00, 8'hFF, 13'h1FFF);
        send({8'h12, 9'h1C3}, 2'b00, 1'b1, 2'd0, "R2");
        send(17'h1FFFF, 2'b00, 1'b1, 2'd0, "R2");
        idle(1);

        // R4: permission codes against every kind
        load(2'b01, 8'h20, 13'd1);
        load(2'b01, 8'h21, 13'd2);
        load(2'b01, 8'h22, 13'd0);
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                send({8'h20 + 8'(p == 3 ? 8'h0 : p), 9'h011} | (p == 3 ? 17'h10 : 17'h0),
                     2'(k), 1'b1, 2'd0, "R4");
            end
        end
        idle(1);

        // R3: unmapped bypasses frames and permission
        send(17'h00010, 2'b01, 1'b0, 2'd2, "R3");
        send({8'h12, 9'h005}, 2'b01, 1'b0, 2'd0, "R3");
        idle(1);

        // R5: lock and key
        load(2'b00, 8'h30, 13'h005);
        load(2'b10, 8'h05, 13'd1);
        load(2'b00, 8'h31, 13'h006);
        for (int k = 0; k < 4; k++) send({8'h30, 9'h002}, 2'b00, 1'b1, 2'(k), "R5");
        send({8'h31, 9'h002}, 2'b00, 1'b1, 2'd3, "R5");
        send({8'h05, 9'h100}, 2'b00, 1'b0, 2'd2, "R5");
        idle(1);

        // R6: lock region boundary
        load(2'b00, 8'h40, 13'h0100);
        load(2'b00, 8'h41, 13'h00FF);
        load(2'b10, 8'hFF, 13'd3);
        send({8'h40, 9'h000}, 2'b00, 1'b1, 2'd1, "R6");
        send({8'h41, 9'h1FF}, 2'b00, 1'b1, 2'd1, "R6");
        idle(1);

        // R9: ignored select, same-cycle load
        load(2'b11, 8'h40, 13'h0000);
        send({8'h40, 9'h044}, 2'b00, 1'b1, 2'd1, "R9");
        load_and_send(2'b00, 8'h50, 13'h077, {8'h50, 9'h033}, 2'd0, "R9");
        send({8'h50, 9'h033}, 2'b00, 1'b1, 2'd0, "R9");
        idle(1);

        // R7: back-to-back stream then gap
        for (int i = 0; i < 6; i++) send(17'(i * 37 + 20), 2'(i), 1'(i % 2), 2'(i), "R7");
        idle(4);

        done = 1'b1;
        check(q.size() == 0, "R7", $sformatf("pending=%0d exp=0", q.size()));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule